// File: doc/BRIEF.md
# Programmable Supervisor Watchdog

This block watches a processor through one 8-bit setup byte. Software writes the byte to arm the watchdog. The byte carries a 5-bit count and a 2-bit time-unit code, and each write starts the timeout period again. The timeout is measured against a 16 Hz time-base strobe. When no write arrives before the timeout ends, the block reacts in one of two ways, chosen by a steering bit. It either drives a reset pulse of fixed length, which also clears the setup byte and so disarms the watchdog, or it raises an interrupt. The interrupt stays high until software writes the byte again or power fails.

Every expiry also sets a sticky flag, and a clear strobe removes it. A power-fail input disarms the watchdog and drops the interrupt, so boot software must arm the block again. The present setup byte can always be read back on a read port.

Top module: `wdog_supervisor`

## Requirements
- R1: After a synchronous active-low reset, `rst_pulse`, `irq`, `wd_flag` are 0 and `cfg_rdata` reads 0x00.
- R2: A write stores `cfg_wdata` so that `cfg_rdata` returns it on the next cycle. The field positions are bit 7 = steering, bits 6..2 = count, bits 1..0 = unit code.
- R3: The timeout spans count × 4^code ticks of `tick_16hz`: code 0 is 1 tick (1/16 s), 1 is 4 ticks, 2 is 16 ticks, 3 is 64 ticks. The response appears on the clock edge that samples the tick completing the period.
- R4: A count of zero disarms the watchdog, and no expiry ever occurs.
- R5: Every accepted write restarts the timeout period from zero ticks.
- R6: With steering = 1, an expiry raises `rst_pulse` at the next edge. The pulse stays high until the edge that samples the RST_TICKS-th following tick (default 2). The setup byte reads 0x00 from the start of the pulse, and writes during the pulse are ignored.
- R7: With steering = 0, an expiry raises `irq`. It stays high until a write or `pwr_fail`, and the timer keeps rearming with the same setting.
- R8: Every expiry sets `wd_flag`. `flag_clr` clears it, and an expiry in the same cycle wins over the clear.
- R9: `pwr_fail` clears the setup byte, drops `irq` and restarts the count; it has priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Setup byte write strobe |
| cfg_wdata | input | 8 | Setup byte write data |
| tick_16hz | input | 1 | One-cycle 16 Hz time-base strobe |
| pwr_fail | input | 1 | Power-failure indication |
| flag_clr | input | 1 | Clears the expiry flag |
| cfg_rdata | output | 8 | Present setup byte |
| rst_pulse | output | 1 | Processor reset pulse, active high |
| irq | output | 1 | Watchdog interrupt, active high |
| wd_flag | output | 1 | Sticky expiry flag |

## Verification
Directed runs arm each unit code with a small count and step single ticks. They check that the response appears on the exact tick of the product rather than one tick early or late, and this separates a wrong unit scale from an off-by-one in the counter. Further directed cases cover a zero count, a write shortly before expiry, a reset pulse with a write inside it, an interrupt cleared by power failure, and an expiry that coincides with a flag clear. A long random phase then mixes writes, sparse ticks, flag clears and rare power failures, and compares every cycle against a bench model derived from the requirements. This phase catches wrong orderings between a write, an expiry and power failure.

// File: rtl/wdog_pkg.sv
// Package: shared field widths and the setup byte layout of the watchdog.
// Assumes the byte is 8 bits: steering, count, unit code, MSB first.
package wdog_pkg;
    localparam int MULT_W  = 5;
    localparam int RES_W   = 2;
    localparam int CFG_W   = 1 + MULT_W + RES_W;
    // Largest shift applied for the top unit code (each code step is x4).
    localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
    localparam int CNT_W   = MULT_W + MAX_SHIFT;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  unit;
    } wd_cfg_t;
endpackage

// File: rtl/wdog_cfg_reg.sv
// Module: holds the setup byte. Cleared by power failure, held at zero while
// a reset pulse is active, otherwise loaded on a write.
// Assumes the pulse indication arrives from the response stage, registered.
module wdog_cfg_reg
    import wdog_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en,
    input  wd_cfg_t wr_data,
    input  logic    pwr_fail,
    input  logic    clr_now,
    input  logic    pulse_on,
    output wd_cfg_t cfg
);
    // Setup byte storage with power-fail and pulse clearing priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cfg <= '0;
        else if (pwr_fail)            cfg <= '0;
        else if (clr_now || pulse_on) cfg <= '0;
        else if (wr_en)               cfg <= wr_data;
    end

    a_r9_pf_clears_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (cfg == '0));
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pwr_fail && !clr_now && !pulse_on) |=> (cfg == $past(wr_data)));
endmodule

// File: rtl/wdog_timer.sv
// Module: counts time-base ticks since the last restart and produces a
// one-cycle expiry strobe when count x 4^unit ticks have elapsed.
// Assumes the tick is a single-cycle strobe; a zero count disarms.
module wdog_timer
    import wdog_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wd_cfg_t cfg,
    input  logic    restart,
    input  logic    tick,
    output logic    expire
);
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] next_elapsed;
    logic             armed;

    // Period in ticks: count shifted left by two bits per unit code step.
    always_comb begin
        limit        = CNT_W'(cfg.mult) << {cfg.unit, 1'b0};
        armed        = (cfg.mult != '0);
        next_elapsed = elapsed + CNT_W'(1);
        expire       = armed && tick && !restart && (next_elapsed == limit);
    end

    // Elapsed-tick counter, cleared on restart, expiry or when disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n)                   elapsed <= '0;
        else if (restart || !armed)   elapsed <= '0;
        else if (expire)              elapsed <= '0;
        else if (tick)                elapsed <= next_elapsed;
    end

    a_r4_zero_never_expires: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mult == '0) |-> !expire);
    a_r5_restart_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (elapsed == '0));
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (elapsed < limit));
endmodule

// File: rtl/wdog_response.sv
// Module: turns an expiry into either a timed reset pulse or a held
// interrupt, and keeps the sticky expiry flag.
// Assumes PULSE_TICKS >= 1 and that expiry cannot coincide with a write.
module wdog_response #(
    parameter int PULSE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic steer,
    input  logic tick,
    input  logic sw_write,
    input  logic pwr_fail,
    input  logic flag_clr,
    output logic pulse_on,
    output logic irq,
    output logic flag
);
    localparam int PC_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
    logic [PC_W-1:0] pulse_cnt;
    logic            pulse_last;

    always_comb pulse_last = (pulse_cnt == PC_W'(PULSE_TICKS - 1));

    // Reset pulse: starts on a steered expiry, ends after PULSE_TICKS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_on  <= 1'b0;
            pulse_cnt <= '0;
        end else if (expire && steer) begin
            pulse_on  <= 1'b1;
            pulse_cnt <= '0;
        end else if (pulse_on && tick) begin
            if (pulse_last) pulse_on <= 1'b0;
            else            pulse_cnt <= pulse_cnt + PC_W'(1);
        end
    end

    // Interrupt: set on unsteered expiry, held until a write or power failure.
    always_ff @(posedge clk) begin
        if (!rst_n)                   irq <= 1'b0;
        else if (pwr_fail || sw_write) irq <= 1'b0;
        else if (expire && !steer)    irq <= 1'b1;
    end

    // Sticky flag: expiry wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (expire)   flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    a_r6_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && steer) |=> pulse_on);
    a_r8_flag_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);
    a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !sw_write && !pwr_fail) |=> irq);
    a_r7_irq_write_drops: assert property (@(posedge clk) disable iff (!rst_n)
        sw_write |=> !irq);
endmodule

// File: rtl/wdog_supervisor.sv
// Module: top of the supervisor watchdog. Connects the setup byte, the tick
// timer and the response stage.
// Assumes synchronous inputs and a one-cycle 16 Hz tick strobe.
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int RST_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             tick_16hz,
    input  logic             pwr_fail,
    input  logic             flag_clr,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             rst_pulse,
    output logic             irq,
    output logic             wd_flag
);
    wd_cfg_t cfg;
    logic    expire;
    logic    pulse_on;
    logic    wr_ok;
    logic    restart;

    // A write counts only outside a reset pulse; power failure restarts too.
    always_comb begin
        wr_ok   = cfg_we && !pulse_on;
        restart = wr_ok || pwr_fail;
    end

    wdog_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .wr_data  (wd_cfg_t'(cfg_wdata)),
        .pwr_fail (pwr_fail),
        .clr_now  (expire && cfg.steer),
        .pulse_on (pulse_on),
        .cfg      (cfg)
    );

    wdog_timer u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .restart (restart),
        .tick    (tick_16hz),
        .expire  (expire)
    );

    wdog_response #(.PULSE_TICKS(RST_TICKS)) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .steer    (cfg.steer),
        .tick     (tick_16hz),
        .sw_write (wr_ok),
        .pwr_fail (pwr_fail),
        .flag_clr (flag_clr),
        .pulse_on (pulse_on),
        .irq      (irq),
        .flag     (wd_flag)
    );

    always_comb begin
        cfg_rdata = cfg;
        rst_pulse = pulse_on;
    end

    a_r6_cfg_zero_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> (cfg_rdata == '0));
    a_r6_pulse_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse) |-> !$rose(irq));
endmodule

// File: tb/sim_wdog_supervisor.sv
module sim_wdog_supervisor;
    localparam int RT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       tick_16hz = 1'b0;
    logic       pwr_fail = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] cfg_rdata;
    logic       rst_pulse, irq, wd_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model state
    logic [7:0] m_reg;
    int         m_cnt, m_rcnt;
    bit         m_rst, m_irq, m_flag;

    always #4 clk = ~clk;

    wdog_supervisor #(.RST_TICKS(RT)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tick_16hz(tick_16hz), .pwr_fail(pwr_fail), .flag_clr(flag_clr),
        .cfg_rdata(cfg_rdata), .rst_pulse(rst_pulse), .irq(irq), .wd_flag(wd_flag)
    );

    function automatic int period(input logic [7:0] b);
        return int'(b[6:2]) * (1 << (2 * int'(b[1:0])));
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_reg = 8'h00; m_cnt = 0; m_rcnt = 0; m_rst = 0; m_irq = 0; m_flag = 0;
    endtask

    // Advance the model by one clock using the inputs now applied.
    task automatic model_step();
        int  lim;
        bit  exp_now, wr;
        lim = period(m_reg);
        wr  = cfg_we && !m_rst;
        exp_now = tick_16hz && (lim != 0) && !wr && !pwr_fail && (m_cnt + 1 == lim);
        if (m_irq && (pwr_fail || wr)) m_irq = 0;
        else if (exp_now && !m_reg[7]) m_irq = 1;
        if (exp_now) m_flag = 1; else if (flag_clr) m_flag = 0;
        if (exp_now && m_reg[7]) begin m_rst = 1; m_rcnt = 0; end
        else if (m_rst && tick_16hz) begin
            if (m_rcnt == RT - 1) m_rst = 0; else m_rcnt++;
        end
        if (wr || pwr_fail || lim == 0 || exp_now) m_cnt = 0;
        else if (tick_16hz) m_cnt++;
        if (pwr_fail) m_reg = 8'h00;
        else if ((exp_now && m_reg[7]) || m_rst) m_reg = 8'h00;
        else if (wr) m_reg = cfg_wdata;
        if (period(m_reg) == 0) m_cnt = 0;
    endtask

    // Apply inputs for one cycle, step the model, compare after the edge.
    task automatic cyc(input string tag, input bit we, input logic [7:0] wd,
                       input bit tk, input bit pf, input bit fc);
        cfg_we = we; cfg_wdata = wd; tick_16hz = tk; pwr_fail = pf; flag_clr = fc;
        model_step();
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0; tick_16hz = 0; pwr_fail = 0; flag_clr = 0;
        chk(tag, "cfg_rdata", int'(cfg_rdata), int'(m_reg));
        chk(tag, "rst_pulse", int'(rst_pulse), int'(m_rst));
        chk(tag, "irq",       int'(irq),       int'(m_irq));
        chk(tag, "wd_flag",   int'(wd_flag),   int'(m_flag));
    endtask

    task automatic ticks(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 0, 8'h00, 1, 0, 0);
    endtask

    initial begin
        int seed;
        logic [7:0] b;
        seed = 1234;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values
        chk("R1", "cfg_rdata", int'(cfg_rdata), 0);
        chk("R1", "rst_pulse", int'(rst_pulse), 0);
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "wd_flag", int'(wd_flag), 0);

        // R2: layout readback, steer=0 count=3 unit=1 -> 12 ticks
        cyc("R2", 1, {1'b0, 5'd3, 2'd1}, 0, 0, 0);
        // R3: exactly 12 ticks, not 11
        ticks("R3", 11);
        chk("R3", "irq before period", int'(irq), 0);
        ticks("R3", 1);
        chk("R3", "irq at period", int'(irq), 1);
        // R7: irq holds across further ticks, timer rearms
        ticks("R7", 30);
        chk("R7", "irq held", int'(irq), 1);
        // R8: flag clear then expiry coinciding with clear
        cyc("R8", 0, 8'h00, 0, 0, 1);
        chk("R8", "flag cleared", int'(wd_flag), 0);
        cyc("R7", 1, {1'b0, 5'd1, 2'd0}, 0, 0, 0);
        chk("R7", "irq dropped by write", int'(irq), 0);
        cyc("R8", 0, 8'h00, 1, 0, 1);
        chk("R8", "expiry wins over clear", int'(wd_flag), 1);

        // R3: each unit code with count 1
        for (int u = 0; u < 4; u++) begin
            cyc("R3", 1, {1'b0, 5'd1, 2'(u)}, 0, 0, 0);
            ticks("R3", (1 << (2 * u)) - 1);
            chk("R3", "no early expiry", int'(irq), 0);
            ticks("R3", 1);
            chk("R3", "expiry at 4^code", int'(irq), 1);
        end

        // R4: zero count never expires
        cyc("R4", 1, {1'b1, 5'd0, 2'd0}, 0, 0, 1);
        ticks("R4", 200);
        chk("R4", "no pulse", int'(rst_pulse), 0);
        chk("R4", "no flag", int'(wd_flag), 0);

        // R5: write 1 tick before expiry restarts
        cyc("R5", 1, {1'b0, 5'd2, 2'd1}, 0, 0, 0);
        ticks("R5", 7);
        cyc("R5", 1, {1'b0, 5'd2, 2'd1}, 0, 0, 0);
        ticks("R5", 7);
        chk("R5", "restarted period", int'(irq), 0);
        ticks("R5", 1);
        chk("R5", "expiry after restart", int'(irq), 1);

        // R6: steered reset pulse, write inside pulse ignored
        cyc("R6", 1, {1'b1, 5'd2, 2'd0}, 0, 0, 0);
        ticks("R6", 2);
        chk("R6", "pulse up", int'(rst_pulse), 1);
        chk("R6", "cfg cleared", int'(cfg_rdata), 0);
        cyc("R6", 1, 8'hFF, 0, 0, 0);
        chk("R6", "write ignored", int'(cfg_rdata), 0);
        ticks("R6", RT - 1);
        chk("R6", "pulse still up", int'(rst_pulse), 1);
        ticks("R6", 1);
        chk("R6", "pulse ended", int'(rst_pulse), 0);

        // R9: power failure beats write, drops irq
        cyc("R9", 1, {1'b0, 5'd1, 2'd0}, 0, 0, 0);
        ticks("R9", 1);
        chk("R9", "irq armed", int'(irq), 1);
        cyc("R9", 1, 8'h7F, 0, 1, 0);
        chk("R9", "cfg cleared", int'(cfg_rdata), 0);
        chk("R9", "irq dropped", int'(irq), 0);
        ticks("R9", 100);
        chk("R9", "stays disarmed", int'(irq), 0);

        // random phase
        for (int i = 0; i < 60000; i++) begin
            bit we, tk, pf, fc;
            b  = 8'($urandom);
            if (b[6:4] != 0 && $urandom_range(0, 3) != 0) b[6:4] = 3'd0;
            we = ($urandom_range(0, 149) == 0);
            tk = ($urandom_range(0, 1) == 0);
            pf = ($urandom_range(0, 2999) == 0);
            fc = ($urandom_range(0, 99) == 0);
            cyc("R2/R6/R7/R8 random", we, b, tk, pf, fc);
        end
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (190000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog timeout actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule